// File: doc/BRIEF.md
# Positional cube operation unit

This block performs set operations on product terms held in positional cube form. A cube is a concatenation of variable fields. Each field has one bit per value the variable can take, and a set bit means that value belongs to the literal. A binary variable takes a 2-bit field. A variable with p values takes a p-bit field. Field widths and their order come from a packed parameter list, so binary and multi-valued variables can be mixed in the same cube.

For each valid input the unit takes two cubes and an operation code. It returns either the intersection of the two cubes, their merge (supercube), the bitwise inversion of the first cube, or the first cube unchanged. Alongside the result it reports:

- which fields of the result are empty;
- whether the result is a single minterm;
- how many fields are fully unspecified;
- the number of minterms the result covers;
- whether the two input cubes differ in exactly one field, in which case their merge is an exact disjunction.

All outputs are registered and appear one cycle after the valid input.

Top module: `pcu_top`

## Requirements
- R1: Field k occupies the bits starting at the sum of the widths of fields 0..k-1, and bit j of a field stands for value j. With the default list {2,3}, field 0 (binary) is bits [1:0] and field 1 (ternary) is bits [4:2]. In a binary field, 01 is value 0, 10 is value 1 and 11 is don't care.
- R2: With inValid high and inOp = 00, the next cycle shows outValid high and outCube equal to the bitwise AND of cubeA and cubeB.
- R3: With inValid high and inOp = 01, the next cycle shows outCube equal to the bitwise OR of cubeA and cubeB.
- R4: With inValid high and inOp = 10, the next cycle shows outCube equal to the bitwise inversion of cubeA. This is a bitwise result, not the set complement, and cubeB has no effect on it.
- R5: With inValid high and inOp = 11, the next cycle shows outCube equal to cubeA unchanged.
- R6: Bit k of emptyMask is set when field k of the result is all zeros. cubeEmpty is set when any bit of emptyMask is set.
- R7: cubeSize is the product of the set-bit counts of all result fields. It is zero whenever any result field is empty.
- R8: isMinterm is set exactly when every result field has exactly one bit set. cubeSize is then 1.
- R9: dcCount is the number of result fields whose bits are all ones.
- R10: mergeOk is set when cubeA and cubeB differ in exactly one field. It is computed from the inputs whatever the operation.
- R11: A cycle with inValid low drives outValid low in the next cycle and leaves every data output at its previous value.
- R12: Reset (rstN low, asynchronous) clears outValid and every data output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input cubes and operation are valid this cycle |
| inOp | input | 2 | 00 intersect, 01 merge, 10 bitwise invert A, 11 pass A |
| cubeA | input | TOTAL_W (5) | First operand cube |
| cubeB | input | TOTAL_W (5) | Second operand cube |
| outValid | output | 1 | Result registers were loaded in the previous cycle |
| outCube | output | TOTAL_W (5) | Result cube |
| emptyMask | output | NUM_FIELDS (2) | Per-field empty flags of the result |
| cubeEmpty | output | 1 | Result has at least one empty field |
| isMinterm | output | 1 | Every result field holds exactly one value |
| dcCount | output | DC_W (2) | Number of all-ones fields in the result |
| cubeSize | output | SIZE_W (3) | Number of minterms covered by the result |
| mergeOk | output | 1 | Inputs differ in exactly one field |

## Verification
The result-derived statistics and the merge test land in the same output cycle, but they are computed from different sources. The merge test looks at the operands. The size, empty and minterm flags look at the result. A mutation that crosses those sources shows up only when both vary together. The bench provokes this with directed merge pairs that differ in one field and in two fields, and with random operand streams under every operation code. Idle cycles fall between them, and a reset is asserted mid-run. Its behavioural model recomputes every flag from the operands and the requirement definitions, and it compares all outputs on every falling edge.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int MAX_FIELDS = 8;

  // Packed list of field widths, field k in byte k.
  typedef logic [MAX_FIELDS*8-1:0] fieldList_t;

  typedef enum logic [1:0] {
    OP_AND   = 2'b00,
    OP_MERGE = 2'b01,
    OP_FLIP  = 2'b10,
    OP_PASS  = 2'b11
  } pcuOp_e;

  typedef struct packed {
    logic capture;
    logic selAnd;
    logic selOr;
    logic selFlip;
    logic selPass;
  } pcuStrobe_t;

  function automatic int fieldWidth(fieldList_t fw, int idx);
    return int'(fw[idx*8 +: 8]);
  endfunction

  function automatic int fieldOffset(fieldList_t fw, int idx);
    int s;
    s = 0;
    for (int k = 0; k < MAX_FIELDS; k++)
      if (k < idx) s += fieldWidth(fw, k);
    return s;
  endfunction

  function automatic int totalWidth(fieldList_t fw, int n);
    return fieldOffset(fw, n);
  endfunction

  function automatic int maxWidth(fieldList_t fw, int n);
    int m;
    m = 1;
    for (int k = 0; k < MAX_FIELDS; k++)
      if (k < n && fieldWidth(fw, k) > m) m = fieldWidth(fw, k);
    return m;
  endfunction

  function automatic int sizeWidth(fieldList_t fw, int n);
    longint p;
    p = 1;
    for (int k = 0; k < MAX_FIELDS; k++)
      if (k < n) p = p * longint'(fieldWidth(fw, k));
    return $clog2(p + 1);
  endfunction

  function automatic int countWidth(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  output pcuStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe = '0;
    strobe.capture = inValid;
    case (pcuOp_e'(inOp))
      OP_AND:   strobe.selAnd  = 1'b1;
      OP_MERGE: strobe.selOr   = 1'b1;
      OP_FLIP:  strobe.selFlip = 1'b1;
      default:  strobe.selPass = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int         NUM_FIELDS = 2,
  parameter fieldList_t FIELD_W    = 64'h0000_0000_0000_0302,
  localparam int TOTAL_W = totalWidth(FIELD_W, NUM_FIELDS),
  localparam int SIZE_W  = sizeWidth(FIELD_W, NUM_FIELDS),
  localparam int DC_W    = countWidth(NUM_FIELDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pcuStrobe_t            strobe,
  input  logic [TOTAL_W-1:0]    cubeA,
  input  logic [TOTAL_W-1:0]    cubeB,
  output logic [TOTAL_W-1:0]    outCube,
  output logic [NUM_FIELDS-1:0] emptyMask,
  output logic                  cubeEmpty,
  output logic                  isMinterm,
  output logic [DC_W-1:0]       dcCount,
  output logic [SIZE_W-1:0]     cubeSize,
  output logic                  mergeOk
);

  localparam int MAX_W = maxWidth(FIELD_W, NUM_FIELDS);
  localparam int CNT_W = countWidth(MAX_W);

  logic [TOTAL_W-1:0]          resNext;
  logic [NUM_FIELDS*CNT_W-1:0] fieldCntFlat;
  logic [NUM_FIELDS-1:0]       fieldEmpty;
  logic [NUM_FIELDS-1:0]       fieldFull;
  logic [NUM_FIELDS-1:0]       fieldOne;
  logic [NUM_FIELDS-1:0]       fieldDiff;
  logic [SIZE_W-1:0]           sizeNext;
  logic [DC_W-1:0]             dcNext;
  logic                        mintNext;
  logic                        mergeNext;

  // Operation select
  always_comb begin
    resNext = cubeA;
    if (strobe.selAnd)       resNext = cubeA & cubeB;
    else if (strobe.selOr)   resNext = cubeA | cubeB;
    else if (strobe.selFlip) resNext = ~cubeA;
  end

  // Per-field analysis
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : gField
    localparam int OFF = fieldOffset(FIELD_W, f);
    localparam int W   = fieldWidth(FIELD_W, f);
    logic [W-1:0]     fieldRes;
    logic [CNT_W-1:0] cnt;

    assign fieldRes = resNext[OFF +: W];

    always_comb begin
      cnt = '0;
      for (int j = 0; j < W; j++) cnt = cnt + CNT_W'(fieldRes[j]);
    end

    assign fieldCntFlat[f*CNT_W +: CNT_W] = cnt;
    assign fieldEmpty[f] = (cnt == '0);
    assign fieldOne[f]   = (cnt == CNT_W'(1));
    assign fieldFull[f]  = &fieldRes;
    assign fieldDiff[f]  = (cubeA[OFF +: W] != cubeB[OFF +: W]);
  end

  // Cube-level statistics
  always_comb begin
    sizeNext = SIZE_W'(1);
    for (int i = 0; i < NUM_FIELDS; i++)
      sizeNext = SIZE_W'(sizeNext * SIZE_W'(fieldCntFlat[i*CNT_W +: CNT_W]));
    if (|fieldEmpty) sizeNext = '0;
  end

  assign dcNext    = DC_W'($countones(fieldFull));
  assign mintNext  = &fieldOne;
  assign mergeNext = ($countones(fieldDiff) == 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCube   <= '0;
      emptyMask <= '0;
      cubeEmpty <= 1'b0;
      isMinterm <= 1'b0;
      dcCount   <= '0;
      cubeSize  <= '0;
      mergeOk   <= 1'b0;
    end else if (strobe.capture) begin
      outCube   <= resNext;
      emptyMask <= fieldEmpty;
      cubeEmpty <= |fieldEmpty;
      isMinterm <= mintNext;
      dcCount   <= dcNext;
      cubeSize  <= sizeNext;
      mergeOk   <= mergeNext;
    end
  end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int         NUM_FIELDS = 2,
  parameter fieldList_t FIELD_W    = 64'h0000_0000_0000_0302,
  localparam int TOTAL_W = totalWidth(FIELD_W, NUM_FIELDS),
  localparam int SIZE_W  = sizeWidth(FIELD_W, NUM_FIELDS),
  localparam int DC_W    = countWidth(NUM_FIELDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [1:0]            inOp,
  input  logic [TOTAL_W-1:0]    cubeA,
  input  logic [TOTAL_W-1:0]    cubeB,
  output logic                  outValid,
  output logic [TOTAL_W-1:0]    outCube,
  output logic [NUM_FIELDS-1:0] emptyMask,
  output logic                  cubeEmpty,
  output logic                  isMinterm,
  output logic [DC_W-1:0]       dcCount,
  output logic [SIZE_W-1:0]     cubeSize,
  output logic                  mergeOk
);

  pcuStrobe_t strobe;

  pcu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pcu_datapath #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cubeA     (cubeA),
    .cubeB     (cubeB),
    .outCube   (outCube),
    .emptyMask (emptyMask),
    .cubeEmpty (cubeEmpty),
    .isMinterm (isMinterm),
    .dcCount   (dcCount),
    .cubeSize  (cubeSize),
    .mergeOk   (mergeOk)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
#(
  parameter int         NUM_FIELDS = 2,
  parameter fieldList_t FIELD_W    = 64'h0000_0000_0000_0302,
  localparam int TOTAL_W = totalWidth(FIELD_W, NUM_FIELDS),
  localparam int SIZE_W  = sizeWidth(FIELD_W, NUM_FIELDS),
  localparam int DC_W    = countWidth(NUM_FIELDS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [1:0]            inOp,
  input logic [TOTAL_W-1:0]    cubeA,
  input logic [TOTAL_W-1:0]    cubeB,
  input logic                  outValid,
  input logic [TOTAL_W-1:0]    outCube,
  input logic [NUM_FIELDS-1:0] emptyMask,
  input logic                  cubeEmpty,
  input logic                  isMinterm,
  input logic [DC_W-1:0]       dcCount,
  input logic [SIZE_W-1:0]     cubeSize,
  input logic                  mergeOk
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b00) |=> (outCube == $past(cubeA & cubeB))); // R2
  AST_MERGE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b01) |=> (outCube == $past(cubeA | cubeB))); // R3
  AST_FLIP_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b10) |=> (outCube == $past(~cubeA))); // R4
  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b11) |=> (outCube == $past(cubeA))); // R5
  AST_EMPTY_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    cubeEmpty == (emptyMask != '0)); // R6
  AST_EMPTY_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cubeEmpty |-> (cubeSize == '0)); // R7
  AST_MINTERM_SIZE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    isMinterm |-> (cubeSize == SIZE_W'(1) && !cubeEmpty && dcCount == '0)); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outCube) && $stable(cubeSize) && $stable(mergeOk))); // R11

endmodule

bind pcu_top pcu_checker #(
  .NUM_FIELDS (NUM_FIELDS),
  .FIELD_W    (FIELD_W)
) u_chk (.*);

// File: tb/tb_pcu_top.sv
module tb_pcu_top;

  localparam int NF = 2;
  localparam int TW = 5;
  int fw  [NF] = '{2, 3};
  int off [NF] = '{0, 2};

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [1:0] inOp;
  logic [4:0] cubeA, cubeB;
  logic       outValid;
  logic [4:0] outCube;
  logic [1:0] emptyMask;
  logic       cubeEmpty, isMinterm, mergeOk;
  logic [1:0] dcCount;
  logic [2:0] cubeSize;

  always #5 clk = ~clk;

  pcu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .cubeA(cubeA), .cubeB(cubeB), .outValid(outValid), .outCube(outCube),
    .emptyMask(emptyMask), .cubeEmpty(cubeEmpty), .isMinterm(isMinterm),
    .dcCount(dcCount), .cubeSize(cubeSize), .mergeOk(mergeOk)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state: what the outputs must show now.
  int expValid, expCube, expMask, expEmpty, expMint, expDc, expSize, expMerge;
  string cubeTag = "R12";
  string validTag = "R12";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(validTag, "outValid", int'(outValid), expValid);
    chk(cubeTag, "outCube", int'(outCube), expCube);
    chk("R6", "emptyMask", int'(emptyMask), expMask);
    chk("R6", "cubeEmpty", int'(cubeEmpty), expEmpty);
    chk("R7", "cubeSize", int'(cubeSize), expSize);
    chk("R8", "isMinterm", int'(isMinterm), expMint);
    chk("R9", "dcCount", int'(dcCount), expDc);
    chk("R10", "mergeOk", int'(mergeOk), expMerge);
  endtask

  task automatic clearModel();
    expValid = 0; expCube = 0; expMask = 0; expEmpty = 0;
    expMint = 0; expDc = 0; expSize = 0; expMerge = 0;
  endtask

  task automatic model(bit v, int op, int a, int b);
    int res, diff, mint;
    expValid = v;
    if (!v) begin
      validTag = "R11"; cubeTag = "R11";
      return;
    end
    validTag = "R2";
    case (op)
      0: begin res = a & b; cubeTag = "R2"; end
      1: begin res = a | b; cubeTag = "R3"; end
      2: begin res = (~a) & 31; cubeTag = "R4"; end
      default: begin res = a; cubeTag = "R5"; end
    endcase
    expCube = res; expMask = 0; expDc = 0; expSize = 1; diff = 0; mint = 1;
    for (int k = 0; k < NF; k++) begin
      int m, fr, n;
      m  = (1 << fw[k]) - 1;
      fr = (res >> off[k]) & m;
      n  = $countones(fr);
      if (n == 0) expMask |= (1 << k);
      if (fr == m) expDc++;
      if (n != 1) mint = 0;
      expSize *= n;
      if (((a >> off[k]) & m) != ((b >> off[k]) & m)) diff++;
    end
    expEmpty = (expMask != 0);
    expMint  = mint;
    expMerge = (diff == 1);
  endtask

  task automatic step(bit v, int op, int a, int b);
    @(negedge clk);
    compareAll();
    inValid = v; inOp = 2'(op); cubeA = 5'(a); cubeB = 5'(b);
    model(v, op, a & 31, b & 31);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inOp = 2'b00; cubeA = '0; cubeB = '0;
    clearModel();
    repeat (3) @(negedge clk);
    compareAll();                      // R12 reset state
    rstN = 1'b1;

    // R1 layout: field0 value1 (10), field1 value1 (010) -> minterm
    step(1, 3, 5'b010_10, 0);
    step(0, 0, 0, 0);
    chk("R1", "minterm layout", int'(isMinterm), 1);
    chk("R1", "minterm size", int'(cubeSize), 1);
    // R1: field0 value0 (01), field1 don't care (111)
    step(1, 3, 5'b111_01, 0);
    step(0, 0, 0, 0);
    chk("R1", "dc field count", int'(dcCount), 1);
    chk("R1", "dc size", int'(cubeSize), 3);
    // R1: binary don't care with empty ternary field
    step(1, 3, 5'b000_11, 0);
    step(0, 0, 0, 0);
    chk("R1", "empty field1", int'(emptyMask), 2);

    // R3/R10: mergeable pair differing only in field0
    step(1, 1, 5'b010_01, 5'b010_10);
    // R10: differ in two fields
    step(1, 1, 5'b010_01, 5'b100_10);
    // R2: intersect giving empty field
    step(1, 0, 5'b010_01, 5'b100_01);
    // R4: inversion ignores B
    step(1, 2, 5'b010_01, 5'b111_11);
    step(1, 2, 5'b010_01, 5'b000_00);
    step(0, 2, 5'b111_11, 5'b111_11);  // R11 idle with live inputs
    step(0, 1, 5'b101_10, 5'b010_01);

    for (int i = 0; i < 600; i++)
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 32), int'($urandom % 32));

    // R12: mid-run asynchronous reset
    step(1, 1, 5'b111_11, 5'b000_00);
    @(negedge clk);
    compareAll();
    rstN = 1'b0; inValid = 1'b0;
    #1;
    clearModel(); validTag = "R12"; cubeTag = "R12";
    compareAll();
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 200; i++)
      step(1, int'($urandom % 4), int'($urandom % 32), int'($urandom % 32));
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule